// File: doc/BRIEF.md
# Constant-Time Bit-Flipping Decoder for Quasi-Cyclic MDPC Codes

This block corrects a two-block quasi-cyclic MDPC ciphertext by iterative bit flipping. It takes the received word, the syndrome already computed for it, and the sparse secret key: for each of the two circulant blocks, the positions of the set bits in that block's first parity-check row. Each ciphertext bit is visited in a fixed order. For the visited bit, a bank of position counters names the syndrome bits that its parity-check row touches. The syndrome bits at those positions are summed to give the count of unsatisfied checks. If the count reaches the threshold for the current iteration, the ciphertext bit is flipped and the syndrome is toggled at every counter position.

Neither the flip nor the syndrome update is skipped. Both always happen, and each is ANDed with the comparison result, so every bit costs one cycle whatever the data is. By default the decoder runs a fixed number of iterations and then reports the corrected word and whether the final syndrome is zero. The thresholds are written into a small register file, one entry per iteration, before the decode starts. An elaboration option allows an early finish once an iteration leaves the syndrome clear. This option gives up constant timing and is off by default.

Top module: `mdpc_bf_decoder`

## Requirements
- R1: With EARLY_EXIT=0, `done_o` pulses exactly ITERS*2*R clock cycles after the edge that accepts `start_i`. This holds for every word, syndrome, key and threshold.
- R2: The unsatisfied-check count for row offset k of block b is the number of set syndrome bits among the positions (p+k) mod R, where p runs over that block's stored first-row positions.
- R3: Within each iteration, block 0 bits (word indices 0..R-1) are visited in ascending order, followed by block 1 bits (indices R..2R-1). The visited bit flips if and only if count >= threshold. Whenever it flips, the syndrome is toggled at all W_HALF positions of that row. The next bit sees the updated syndrome.
- R4: Iteration i compares against threshold entry i. That entry is written through `thr_we_i`/`thr_addr_i`/`thr_data_i` while the decoder is idle. Writes to addresses >= ITERS are dropped.
- R5: The position counters reload from the stored first-row positions at the start of every block pass in every iteration. They advance by one per bit and wrap from R-1 to 0, so each counter always holds a value below R.
- R6: A bit never flips while the current syndrome is all zero, even when the threshold is 0. Once the syndrome is clear, the word and syndrome stay unchanged for the rest of the run.
- R7: At the `done_o` pulse, `ok_o` is 1 exactly when the final syndrome is zero. `word_o` then holds the corrected word unchanged until the next accepted start.
- R8: A `start_i` asserted while `busy_o` is high is ignored. It changes neither the result nor the latency of the running decode.
- R9: With EARLY_EXIT=1, the decode finishes after the first iteration whose ending syndrome is zero, so the latency is (that iteration count)*2*R. Otherwise it behaves as in R1.
- R10: `busy_o` is high from the cycle after the accepting edge until `done_o`. `done_o` is a single-cycle pulse. After reset, `busy_o`, `done_o`, `ok_o` and `word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_we_i | input | 1 | Threshold register write enable |
| thr_addr_i | input | ITER_W | Iteration index of the threshold write |
| thr_data_i | input | THR_W | Threshold value |
| key_pos_i | input | 2*W_HALF*IDX_W | First-row positions; entry b*W_HALF+j at bits [(b*W_HALF+j)*IDX_W +: IDX_W] |
| word_i | input | 2*R | Received ciphertext, block 0 in the low R bits |
| syn_i | input | R | Initial syndrome |
| start_i | input | 1 | Start request, accepted only when idle |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Final syndrome is zero |
| word_o | output | 2*R | Corrected word |

## Verification
The bench builds two copies with R=11, W_HALF=3 and ITERS=5 and drives both with the same inputs. One has EARLY_EXIT off and the other has it on, so the fixed latency of 110 cycles and the shortened latency are compared on every run. A circulant of 11 with three taps per block makes row overlaps and counter wraparound frequent. It also lets a few random errors push the decoder into both converging and failing outcomes. The thresholds sweep from 0 to W_HALF+1, which covers the "always flip" and "never flip" extremes alongside the meaningful middle values.

// File: rtl/mdpc_pkg.sv
package mdpc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} dec_state_e;
endpackage

// File: rtl/mdpc_pos_ctr.sv
module mdpc_pos_ctr #(
  parameter int R      = 101,
  parameter int W_HALF = 5,
  localparam int IDX_W = $clog2(R),
  localparam int BLK_W = W_HALF * IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BLK_W-1:0] pos_i,
  input  logic             step_i,
  output logic [BLK_W-1:0] ctr_o
);
  logic [BLK_W-1:0] ctr_q;

  for (genvar j = 0; j < W_HALF; j++) begin : g_ctr
    logic [IDX_W:0]   inc;
    logic             keep;
    logic [IDX_W-1:0] nxt;
    // masked wrap: same logic path whether or not the counter rolls over
    assign inc  = {1'b0, ctr_q[j*IDX_W +: IDX_W]} + (IDX_W+1)'(1);
    assign keep = inc < (IDX_W+1)'(R);
    assign nxt  = inc[IDX_W-1:0] & {IDX_W{keep}};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ctr_q[j*IDX_W +: IDX_W] <= '0;
      else if (load_i) ctr_q[j*IDX_W +: IDX_W] <= pos_i[j*IDX_W +: IDX_W];
      else if (step_i) ctr_q[j*IDX_W +: IDX_W] <= nxt;
    end

    AST_CTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctr_q[j*IDX_W +: IDX_W] < IDX_W'(R)); // R5
  end

  assign ctr_o = ctr_q;
endmodule

// File: rtl/mdpc_upc_count.sv
module mdpc_upc_count #(
  parameter int R      = 101,
  parameter int W_HALF = 5,
  localparam int IDX_W = $clog2(R),
  localparam int BLK_W = W_HALF * IDX_W,
  localparam int CNT_W = $clog2(W_HALF + 2)
) (
  input  logic [R-1:0]     syn_i,
  input  logic [BLK_W-1:0] ctr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int j = 0; j < W_HALF; j++)
      cnt_o = cnt_o + CNT_W'(syn_i[ctr_i[j*IDX_W +: IDX_W]]);
  end
endmodule

// File: rtl/mdpc_bf_decoder.sv
module mdpc_bf_decoder
  import mdpc_pkg::*;
#(
  parameter int R          = 101,
  parameter int W_HALF     = 5,
  parameter int ITERS      = 5,
  parameter bit EARLY_EXIT = 1'b0,
  localparam int IDX_W  = $clog2(R),
  localparam int N      = 2 * R,
  localparam int THR_W  = $clog2(W_HALF + 2),
  localparam int ITER_W = (ITERS > 1) ? $clog2(ITERS) : 1,
  localparam int BLK_W  = W_HALF * IDX_W,
  localparam int KEY_W  = 2 * BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_we_i,
  input  logic [ITER_W-1:0] thr_addr_i,
  input  logic [THR_W-1:0]  thr_data_i,
  input  logic [KEY_W-1:0]  key_pos_i,
  input  logic [N-1:0]      word_i,
  input  logic [R-1:0]      syn_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [N-1:0]      word_o
);
  dec_state_e        state_q;
  logic [ITER_W-1:0] iter_q;
  logic              blk_q;
  logic [IDX_W-1:0]  k_q;
  logic [N-1:0]      word_q, word_nxt;
  logic [R-1:0]      syn_q, syn_nxt, row_mask;
  logic [KEY_W-1:0]  key_q;
  logic [THR_W-1:0]  thr_q [ITERS];
  logic [BLK_W-1:0]  ctr, load_pos;
  logic [THR_W-1:0]  upc;
  logic              run, accept, last_k, last_iter, end_iter, finish, flip;
  logic              ctr_load, ctr_step, done_q, ok_q;

  // threshold register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ITERS; i++) thr_q[i] <= '0;
    end else if (thr_we_i && !run && int'(thr_addr_i) < ITERS) begin
      thr_q[thr_addr_i] <= thr_data_i;
    end
  end

  assign run       = (state_q == ST_RUN);
  assign accept    = !run && start_i;
  assign last_k    = (k_q == IDX_W'(R - 1));
  assign last_iter = (iter_q == ITER_W'(ITERS - 1));
  assign end_iter  = run && last_k && blk_q;

  mdpc_upc_count #(.R(R), .W_HALF(W_HALF)) u_count (
    .syn_i (syn_q),
    .ctr_i (ctr),
    .cnt_o (upc)
  );

  // flip is masked, never branched; a clear syndrome freezes the data
  assign flip = run && (upc >= thr_q[iter_q]) && (|syn_q);

  always_comb begin
    row_mask = '0;
    for (int j = 0; j < W_HALF; j++) row_mask[ctr[j*IDX_W +: IDX_W]] = 1'b1;
  end

  assign syn_nxt = syn_q ^ (row_mask & {R{flip}});

  always_comb begin
    int bit_idx;
    bit_idx  = int'(k_q) + (blk_q ? R : 0);
    word_nxt = word_q;
    word_nxt[bit_idx] = word_q[bit_idx] ^ flip;
  end

  assign finish   = end_iter && (last_iter || (EARLY_EXIT && (syn_nxt == '0)));
  assign ctr_load = accept || (run && last_k && !finish);
  assign ctr_step = run && !last_k;
  assign load_pos = !run  ? key_pos_i[BLK_W-1:0] :
                    blk_q ? key_q[BLK_W-1:0] : key_q[KEY_W-1:BLK_W];

  mdpc_pos_ctr #(.R(R), .W_HALF(W_HALF)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctr_load),
    .pos_i  (load_pos),
    .step_i (ctr_step),
    .ctr_o  (ctr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      blk_q   <= 1'b0;
      k_q     <= '0;
      word_q  <= '0;
      syn_q   <= '0;
      key_q   <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        iter_q  <= '0;
        blk_q   <= 1'b0;
        k_q     <= '0;
        word_q  <= word_i;
        syn_q   <= syn_i;
        key_q   <= key_pos_i;
        ok_q    <= 1'b0;
      end else if (run) begin
        word_q <= word_nxt;
        syn_q  <= syn_nxt;
        if (last_k) begin
          k_q   <= '0;
          blk_q <= ~blk_q;
          if (blk_q) iter_q <= iter_q + ITER_W'(1);
        end else begin
          k_q <= k_q + IDX_W'(1);
        end
        if (finish) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          ok_q    <= (syn_nxt == '0);
        end
      end
    end
  end

  assign busy_o = run;
  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign word_o = word_q;

  AST_UPC_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc <= THR_W'(W_HALF)); // R2
  AST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && syn_q == '0) |=> ($stable(syn_q) && $stable(word_q))); // R6
  AST_OK_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ok_o == (syn_q == '0))); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(word_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_BUSY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R10
endmodule

// File: tb/mdpc_bf_decoder_tb.sv
`timescale 1ns/1ps
module mdpc_bf_decoder_tb;
  localparam int R = 11, W = 3, ITERS = 5;
  localparam int IDX_W = $clog2(R), N = 2 * R, THR_W = $clog2(W + 2);
  localparam int ITER_W = $clog2(ITERS), KEY_W = 2 * W * IDX_W;
  localparam int FULL = ITERS * 2 * R;

  logic clk = 1'b0, rst_n = 1'b0;
  logic thr_we = 1'b0, start = 1'b0;
  logic [ITER_W-1:0] thr_addr = '0;
  logic [THR_W-1:0]  thr_data = '0;
  logic [KEY_W-1:0]  key_pos = '0;
  logic [N-1:0]      word_in = '0, word_a, word_b;
  logic [R-1:0]      syn_in = '0;
  logic busy_a, done_a, ok_a, busy_b, done_b, ok_b;

  int n_tests = 0, n_fail = 0;
  int pos [2][W];
  int thr [ITERS];

  always #2 clk = ~clk;

  mdpc_bf_decoder #(.R(R), .W_HALF(W), .ITERS(ITERS), .EARLY_EXIT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .thr_we_i(thr_we), .thr_addr_i(thr_addr),
    .thr_data_i(thr_data), .key_pos_i(key_pos), .word_i(word_in), .syn_i(syn_in),
    .start_i(start), .busy_o(busy_a), .done_o(done_a), .ok_o(ok_a), .word_o(word_a));

  mdpc_bf_decoder #(.R(R), .W_HALF(W), .ITERS(ITERS), .EARLY_EXIT(1'b1)) u_dut_early (
    .clk_i(clk), .rst_ni(rst_n), .thr_we_i(thr_we), .thr_addr_i(thr_addr),
    .thr_data_i(thr_data), .key_pos_i(key_pos), .word_i(word_in), .syn_i(syn_in),
    .start_i(start), .busy_o(busy_b), .done_o(done_b), .ok_o(ok_b), .word_o(word_b));

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [R-1:0] syn_of(input logic [N-1:0] e);
    logic [R-1:0] s = '0;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < R; k++)
        if (e[b*R+k]) for (int j = 0; j < W; j++) s[(pos[b][j]+k)%R] ^= 1'b1;
    return s;
  endfunction

  task automatic model(input logic [N-1:0] w0, input logic [R-1:0] s0, input bit early,
                       output logic [N-1:0] w, output logic [R-1:0] s, output int lat);
    int cnt;
    w = w0; s = s0; lat = FULL;
    for (int it = 0; it < ITERS; it++) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < R; k++) begin
          cnt = 0;
          for (int j = 0; j < W; j++) cnt += s[(pos[b][j]+k)%R];
          if (cnt >= thr[it] && s != '0) begin
            w[b*R+k] ^= 1'b1;
            for (int j = 0; j < W; j++) s[(pos[b][j]+k)%R] ^= 1'b1;
          end
        end
      if (early && s == '0) begin lat = (it + 1) * 2 * R; break; end
    end
  endtask

  task automatic rand_key();
    int v; bit dup;
    for (int b = 0; b < 2; b++)
      for (int j = 0; j < W; j++) begin
        do begin
          v = $urandom % R; dup = 0;
          for (int q = 0; q < j; q++) if (pos[b][q] == v) dup = 1;
        end while (dup);
        pos[b][j] = v;
      end
  endtask

  // glitch_at >= 0 pulses start at that offset during the run
  task automatic run_dec(input string req, input logic [N-1:0] w0,
                         input logic [R-1:0] s0, input int glitch_at);
    logic [N-1:0] ew_a, ew_b; logic [R-1:0] es_a, es_b;
    int el_a, el_b, la, lb, m;
    for (int i = 0; i < ITERS; i++) begin
      thr_we = 1'b1; thr_addr = ITER_W'(i); thr_data = THR_W'(thr[i]);
      @(negedge clk);
    end
    thr_we = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int j = 0; j < W; j++) key_pos[(b*W+j)*IDX_W +: IDX_W] = IDX_W'(pos[b][j]);
    word_in = w0; syn_in = s0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10", "busy after start", {63'd0, busy_a}, 64'd1);
    la = -1; lb = -1; m = 0;
    while ((la < 0 || lb < 0) && m < 4 * FULL) begin
      if (done_a && la < 0) la = m;
      if (done_b && lb < 0) lb = m;
      if (m == glitch_at) begin start = 1'b1; word_in = ~w0; syn_in = ~s0; end
      else start = 1'b0;
      @(negedge clk);
      m++;
    end
    start = 1'b0;
    model(w0, s0, 1'b0, ew_a, es_a, el_a);
    model(w0, s0, 1'b1, ew_b, es_b, el_b);
    check(req, "word", 64'(word_a), 64'(ew_a));
    check(req, "ok", {63'd0, ok_a}, {63'd0, es_a == '0});
    check(glitch_at >= 0 ? "R8" : "R1", "latency", 64'(la), 64'(el_a));
    check("R9", "early word", 64'(word_b), 64'(ew_b));
    check("R9", "early latency", 64'(lb), 64'(el_b));
    check("R10", "done pulse width", {63'd0, done_a}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] w, e, held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10", "reset busy", {63'd0, busy_a}, 64'd0);
    check("R10", "reset done", {63'd0, done_a}, 64'd0);
    check("R10", "reset ok",   {63'd0, ok_a},   64'd0);
    check("R10", "reset word", 64'(word_a), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: clear syndrome with threshold 0 must not flip anything
    rand_key();
    for (int i = 0; i < ITERS; i++) thr[i] = 0;
    w = N'({$urandom, $urandom});
    run_dec("R6", w, '0, -1);
    check("R6", "word untouched", 64'(word_a), 64'(w));

    // R3/R7: threshold above row weight never flips, nonzero syndrome fails
    for (int i = 0; i < ITERS; i++) thr[i] = W + 1;
    run_dec("R7", w, R'(11'h2a5), -1);
    check("R3", "no flip", 64'(word_a), 64'(w));
    check("R7", "fail flag", {63'd0, ok_a}, 64'd0);

    // R3: single error with full-weight threshold
    for (int i = 0; i < ITERS; i++) thr[i] = W;
    e = '0; e[R+4] = 1'b1;
    run_dec("R3", w ^ e, syn_of(e), -1);

    // R8: start while busy is ignored
    thr[0] = 3; thr[1] = 2; thr[2] = 2; thr[3] = 2; thr[4] = 1;
    e = '0; e[2] = 1'b1; e[R+7] = 1'b1;
    run_dec("R8", w ^ e, syn_of(e), 5);

    // R7: word held after done
    held = word_a;
    repeat (6) @(negedge clk);
    check("R7", "word held", 64'(word_a), 64'(held));

    // R2/R4/R5: random keys, errors and per-iteration thresholds
    for (int t = 0; t < 30; t++) begin
      rand_key();
      for (int i = 0; i < ITERS; i++) thr[i] = 1 + ($urandom % 3);
      if (t % 5 == 0) thr[t % ITERS] = $urandom % (W + 2);
      e = '0;
      for (int q = 0; q < 1 + ($urandom % 3); q++) e[$urandom % N] = 1'b1;
      w = N'({$urandom, $urandom});
      run_dec(t % 3 == 0 ? "R2" : (t % 3 == 1 ? "R4" : "R5"), w, syn_of(e ^ N'($urandom & 1)), -1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule